// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns a system clock into CAN bit timing. A prescaler makes time quanta. Each bit is built from a one-quantum synchronization slot, a propagation slot, a first phase slot and a second phase slot. The receive line is sampled where the first phase slot hands over to the second. The sampled value goes to the frame logic. A bit-boundary strobe tells the transmit side when to present its next bit.

Falling (recessive-to-dominant) edges on the receive line keep the bit grid aligned to the bus. While the frame logic reports the bus as idle, an edge restarts the bit outright (hard synchronization). Otherwise the unit measures the edge's phase error in quanta. A late edge stretches the first phase slot and an early edge cuts the second phase slot. The change is never more than the programmed jump width.

The sampled-bit output is a valid-only stream. `sample_stb_o` is the valid, and there is no ready. The bus cannot be stalled, so the consumer must take `sample_bit_o` in the cycle the strobe is high. Configuration and status pins are plain levels.

Top module: `can_bit_timing`

## Requirements
- R1: With prescaler value P, a time quantum lasts 2*(P+1) clock cycles. A bit with no synchronization lasts 1 + prop + phase1 + phase2 quanta, measured from one `bit_stb_o` pulse to the next.
- R2: `sample_stb_o` pulses 1 + prop + phase1 quanta after the bit starts, extended by any lengthening. `sample_bit_o` carries the synchronized receive level at that point (1 = recessive, 0 = dominant).
- R3: Each length field (prop, phase1, phase2, jump width) holds the length minus one, so field values 0..7 mean 1..8 quanta.
- R4: When prop + phase1 < phase2, or phase2 < jump width, `cfg_err_o` is high. While it is high, the timing state is held at the start of a bit and neither strobe fires. After a valid configuration returns, the first sample comes 1 + prop + phase1 quanta later.
- R5: A falling receive edge while `bus_idle_i` is high restarts the bit from any position. With the default two synchronizer stages, an edge presented before rising clock edge k raises `bit_stb_o` just after edge k+2.
- R6: A falling edge inside the synchronization quantum has zero phase error. It changes no segment length and does not use up the bit's resynchronization.
- R7: A falling edge in quantum q after the synchronization slot, before the sample point, lengthens phase1 by min(q, jump width) quanta.
- R8: A falling edge in phase2 with e quanta of phase2 left, counting the current one, where e > jump width, shortens phase2 by the jump width.
- R9: A falling edge in phase2 with e <= jump width ends the bit at once. `bit_stb_o` fires with the same latency as in R5, and a full bit follows from there.
- R10: Rising receive edges never change timing.
- R11: At most one resynchronization with nonzero phase error is taken per bit. Later edges in the same bit are ignored.
- R12: After a dominant (0) sample, falling edges in the rest of that bit's phase2 are ignored.
- R13: `sample_stb_o` is a one-cycle pulse. It fires at most once between bit-boundary strobes and never in the same cycle as `bit_stb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brp_i | input | BRP_W | Prescaler value P; quantum = 2*(P+1) clocks |
| prop_i | input | LEN_W | Propagation length minus one |
| ph1_i | input | LEN_W | Phase 1 length minus one |
| ph2_i | input | LEN_W | Phase 2 length minus one |
| sjw_i | input | LEN_W | Jump width minus one |
| bus_idle_i | input | 1 | High when frame logic sees an idle bus (selects hard sync) |
| rx_i | input | 1 | Receive line, asynchronous, 1 = recessive |
| sample_stb_o | output | 1 | Valid strobe for the sampled bit (no ready) |
| sample_bit_o | output | 1 | Bus level taken at the sample point |
| bit_stb_o | output | 1 | Pulse at the start of each bit's synchronization slot |
| cfg_err_o | output | 1 | Configuration breaks an ordering rule |

## Verification
The assertions check the strobe rules on every cycle: a single-cycle sample pulse, one sample per bit, no overlap with the bit boundary, and silence while the configuration is illegal. Phase-error arithmetic can only be shown by the directed scenarios, which place edges mid-quantum and measure strobe timing in clock cycles. That arithmetic covers the clipping to the jump width, the split between early and late edges, the one-per-bit and dominant-sample lockouts, hard restarts, and the prescaler and field encodings.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_TSEG1 = 2'd1,
    SEG_TSEG2 = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp,
  input  logic             clr,
  output logic             tq_tick
);
  localparam int CW = BRP_W + 1;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  // 2*(P+1)-1 = 2P+1
  assign last    = {brp, 1'b1};
  assign tq_tick = (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || tq_tick) cnt <= '0;
    else                          cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              rx_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= rx_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], rx_i};
      end
    end
  endgenerate

  assign rx_s = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) rx_d <= 1'b1;
    else        rx_d <= rx_s;
  end

  assign fall = rx_d & ~rx_s;
endmodule

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
  parameter int LEN_W = 3,
  parameter int CNT_W = 5
) (
  input  logic [LEN_W-1:0] prop_f,
  input  logic [LEN_W-1:0] ph1_f,
  input  logic [LEN_W-1:0] ph2_f,
  input  logic [LEN_W-1:0] sjw_f,
  output logic [CNT_W-1:0] prop_len,
  output logic [CNT_W-1:0] ph1_len,
  output logic [CNT_W-1:0] ph2_len,
  output logic [CNT_W-1:0] sjw_len,
  output logic             err
);
  assign prop_len = CNT_W'(prop_f) + CNT_W'(1);
  assign ph1_len  = CNT_W'(ph1_f)  + CNT_W'(1);
  assign ph2_len  = CNT_W'(ph2_f)  + CNT_W'(1);
  assign sjw_len  = CNT_W'(sjw_f)  + CNT_W'(1);

  assign err = ((prop_len + ph1_len) < ph2_len) || (ph2_len < sjw_len);
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             fall,
  input  logic             rx_s,
  input  logic             bus_idle,
  input  logic             cfg_err,
  input  logic [CNT_W-1:0] prop_len,
  input  logic [CNT_W-1:0] ph1_len,
  input  logic [CNT_W-1:0] ph2_len,
  input  logic [CNT_W-1:0] sjw_len,
  output logic             restart,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_stb
);
  seg_e             seg, seg_n;
  logic [CNT_W-1:0] cnt, cnt_n, ext, ext_n, shr, shr_n;
  logic             used, used_n;
  logic             samp_n, sbit_n, bstb_n;
  logic             soft_ok;
  logic [CNT_W-1:0] err_late, err_early, amt_late;

  assign err_late  = cnt + CNT_W'(1);
  assign err_early = ph2_len - cnt;
  assign amt_late  = (err_late < sjw_len) ? err_late : sjw_len;

  assign soft_ok = fall && !bus_idle && !used &&
                   !(seg == SEG_TSEG2 && !sample_bit);

  assign restart = !cfg_err &&
                   ((fall && bus_idle) ||
                    (soft_ok && seg == SEG_TSEG2 && err_early <= sjw_len));

  always_comb begin
    seg_n  = seg;
    cnt_n  = cnt;
    ext_n  = ext;
    shr_n  = shr;
    used_n = used;
    samp_n = 1'b0;
    bstb_n = 1'b0;
    sbit_n = sample_bit;
    if (cfg_err) begin
      seg_n  = SEG_SYNC;
      cnt_n  = '0;
      ext_n  = '0;
      shr_n  = '0;
      used_n = 1'b0;
    end else if (restart) begin
      seg_n  = SEG_SYNC;
      cnt_n  = '0;
      ext_n  = '0;
      shr_n  = '0;
      used_n = 1'b0;
      bstb_n = 1'b1;
    end else begin
      if (soft_ok && seg == SEG_TSEG1) begin
        ext_n  = amt_late;
        used_n = 1'b1;
      end
      if (soft_ok && seg == SEG_TSEG2) begin
        shr_n  = sjw_len;
        used_n = 1'b1;
      end
      if (tq_tick) begin
        case (seg)
          SEG_SYNC: begin
            seg_n = SEG_TSEG1;
            cnt_n = '0;
          end
          SEG_TSEG1: begin
            if (err_late >= prop_len + ph1_len + ext_n) begin
              seg_n  = SEG_TSEG2;
              cnt_n  = '0;
              samp_n = 1'b1;
              sbit_n = rx_s;
            end else begin
              cnt_n = err_late;
            end
          end
          SEG_TSEG2: begin
            if (err_late >= ph2_len - shr_n) begin
              seg_n  = SEG_SYNC;
              cnt_n  = '0;
              ext_n  = '0;
              shr_n  = '0;
              used_n = 1'b0;
              bstb_n = 1'b1;
            end else begin
              cnt_n = err_late;
            end
          end
          default: begin
            seg_n = SEG_SYNC;
            cnt_n = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg        <= SEG_SYNC;
      cnt        <= '0;
      ext        <= '0;
      shr        <= '0;
      used       <= 1'b0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
      bit_stb    <= 1'b0;
    end else begin
      seg        <= seg_n;
      cnt        <= cnt_n;
      ext        <= ext_n;
      shr        <= shr_n;
      used       <= used_n;
      sample_stb <= samp_n;
      sample_bit <= sbit_n;
      bit_stb    <= bstb_n;
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
  parameter int BRP_W       = 6,
  parameter int LEN_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [LEN_W-1:0] prop_i,
  input  logic [LEN_W-1:0] ph1_i,
  input  logic [LEN_W-1:0] ph2_i,
  input  logic [LEN_W-1:0] sjw_i,
  input  logic             bus_idle_i,
  input  logic             rx_i,
  output logic             sample_stb_o,
  output logic             sample_bit_o,
  output logic             bit_stb_o,
  output logic             cfg_err_o
);
  localparam int LEN_MAX = 1 << LEN_W;
  localparam int CNT_W   = $clog2(3 * LEN_MAX + 1);

  logic             tq_tick, restart, rx_s, fall;
  logic [CNT_W-1:0] prop_len, ph1_len, ph2_len, sjw_len;

  can_bt_cfg #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cfg (
    .prop_f(prop_i), .ph1_f(ph1_i), .ph2_f(ph2_i), .sjw_f(sjw_i),
    .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len),
    .sjw_len(sjw_len), .err(cfg_err_o)
  );

  can_bt_presc #(.BRP_W(BRP_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .brp(brp_i),
    .clr(restart | cfg_err_o), .tq_tick(tq_tick)
  );

  can_bt_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .rx_s(rx_s), .fall(fall)
  );

  can_bt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .fall(fall),
    .rx_s(rx_s), .bus_idle(bus_idle_i), .cfg_err(cfg_err_o),
    .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len),
    .sjw_len(sjw_len), .restart(restart),
    .sample_stb(sample_stb_o), .sample_bit(sample_bit_o),
    .bit_stb(bit_stb_o)
  );
endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_stb,
  input logic bit_stb,
  input logic cfg_err
);
  logic sampled;

  always_ff @(posedge clk) begin
    if (!rst_n || bit_stb || cfg_err) sampled <= 1'b0;
    else if (sample_stb)              sampled <= 1'b1;
  end

  // R13: single-cycle valid pulse
  a_r13_sample_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R13: at most one sample between bit boundaries
  a_r13_one_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !sampled);

  // R13: sample and boundary never coincide
  a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_stb));

  // R4: illegal configuration silences both strobes
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> (!sample_stb && !bit_stb));
endmodule

bind can_bit_timing can_bit_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb_o),
  .bit_stb(bit_stb_o), .cfg_err(cfg_err_o)
);

// File: tb/tb_can_bit_timing.sv
`timescale 1ns/1ps
module tb_can_bit_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] brp = 6'd4;
  logic [2:0] prop = 3'd1, ph1 = 3'd2, ph2 = 3'd3, sjw = 3'd1;
  logic       idle = 1'b0;
  logic       rx = 1'b1;
  logic       sample_stb, sample_bit, bit_stb, cfg_err;
  int         n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  can_bit_timing dut (
    .clk(clk), .rst_n(rst_n), .brp_i(brp), .prop_i(prop), .ph1_i(ph1),
    .ph2_i(ph2), .sjw_i(sjw), .bus_idle_i(idle), .rx_i(rx),
    .sample_stb_o(sample_stb), .sample_bit_o(sample_bit),
    .bit_stb_o(bit_stb), .cfg_err_o(cfg_err)
  );

  // Default: quantum 10 clocks, prop 2, ph1 3, ph2 4, jump 2 -> 10 quanta
  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_bit();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (bit_stb) break;
    end
  endtask

  // Counts negedges from a bit start until the next bit strobe.
  task automatic run_bit(input int f1, input int r1, input int f2,
                         output int samp_n, output int bit_n,
                         output int sbit, output int nsamp);
    samp_n = 0; bit_n = -1; sbit = -1; nsamp = 0;
    for (int n = 1; n <= 400; n++) begin
      @(negedge clk);
      if (sample_stb) begin nsamp++; samp_n = n; sbit = int'(sample_bit); end
      if (bit_stb) begin bit_n = n; break; end
      if (n == f1) rx = 1'b0;
      if (n == r1) rx = 1'b1;
      if (n == f2) rx = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R13 reset sample_stb", int'(sample_stb), 0);
    chk("R13 reset bit_stb", int'(bit_stb), 0);
    chk("R4 reset cfg_err", int'(cfg_err), 0);
    chk("R2 reset sample_bit", int'(sample_bit), 1);
  endtask

  task automatic t_nominal();
    int s, b, v, k;
    run_bit(0, 0, 0, s, b, v, k);
    chk("R2 nominal sample time", s, 60);
    chk("R1 nominal bit length", b, 100);
    chk("R2 recessive sample value", v, 1);
    chk("R13 one sample per bit", k, 1);
  endtask

  task automatic t_alt_cfg();
    int s, b, v, k;
    brp = 6'd1; prop = 3'd0; ph1 = 3'd0; ph2 = 3'd1; sjw = 3'd0;
    run_bit(0, 0, 0, s, b, v, k);
    chk("R1 R3 short cfg sample", s, 12);
    chk("R1 R3 short cfg bit", b, 20);
    brp = 6'd4; prop = 3'd1; ph1 = 3'd2; ph2 = 3'd3; sjw = 3'd1;
    run_bit(0, 0, 0, s, b, v, k);
    chk("R3 restored bit", b, 100);
  endtask

  task automatic t_sync_and_rise();
    int s, b, v, k;
    run_bit(2, 0, 0, s, b, v, k);
    chk("R6 sync-slot edge sample", s, 60);
    chk("R6 sync-slot edge bit", b, 100);
    chk("R2 dominant sample value", v, 0);
    run_bit(0, 22, 0, s, b, v, k);
    chk("R10 rising edge sample", s, 60);
    chk("R10 rising edge bit", b, 100);
    chk("R10 value after rise", v, 1);
  endtask

  task automatic t_late();
    int s, b, v, k;
    run_bit(12, 75, 0, s, b, v, k);
    chk("R7 late q1 sample", s, 70);
    chk("R7 late q1 bit", b, 110);
    run_bit(32, 85, 0, s, b, v, k);
    chk("R7 late q3 clipped sample", s, 80);
    chk("R7 late q3 clipped bit", b, 120);
  endtask

  task automatic t_once();
    int s, b, v, k;
    run_bit(12, 16, 32, s, b, v, k);
    rx = 1'b1;
    chk("R11 second edge ignored sample", s, 70);
    chk("R11 second edge ignored bit", b, 110);
  endtask

  task automatic t_early();
    int s, b, v, k;
    run_bit(62, 0, 0, s, b, v, k);
    rx = 1'b1;
    chk("R8 early cut sample", s, 60);
    chk("R8 early cut bit", b, 80);
    run_bit(82, 0, 0, s, b, v, k);
    rx = 1'b1;
    chk("R9 early restart bit", b, 85);
    run_bit(0, 0, 0, s, b, v, k);
    chk("R9 bit after restart sample", s, 60);
    chk("R9 bit after restart", b, 100);
  endtask

  task automatic t_dominant_lock();
    int s, b, v, k;
    run_bit(2, 62, 72, s, b, v, k);
    rx = 1'b1;
    chk("R12 sample value", v, 0);
    chk("R12 edge after dominant ignored", b, 100);
  endtask

  task automatic t_hard();
    int s, b, v, k;
    idle = 1'b1;
    run_bit(32, 0, 0, s, b, v, k);
    chk("R5 hard sync restart", b, 35);
    chk("R5 no sample before restart", k, 0);
    run_bit(0, 0, 0, s, b, v, k);
    chk("R5 bit after hard sync sample", s, 60);
    chk("R5 bit after hard sync", b, 100);
    idle = 1'b0;
    rx = 1'b1;
  endtask

  task automatic t_cfg_err();
    int s, b, v, k, strobes;
    ph2 = 3'd7;
    @(negedge clk);
    chk("R4 ph2 too long flags", int'(cfg_err), 1);
    strobes = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sample_stb || bit_stb) strobes++;
    end
    chk("R4 strobes while illegal", strobes, 0);
    ph2 = 3'd3; sjw = 3'd4;
    @(negedge clk);
    chk("R4 jump above ph2 flags", int'(cfg_err), 1);
    sjw = 3'd1;
    #0;
    chk("R4 legal clears", int'(cfg_err), 0);
    run_bit(0, 0, 0, s, b, v, k);
    chk("R4 first sample after recovery", s, 60);
    chk("R4 first bit after recovery", b, 100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    wait_bit();
    t_nominal();
    t_alt_cfg();
    t_sync_and_rise();
    t_late();
    t_once();
    t_early();
    t_dominant_lock();
    t_hard();
    t_cfg_err();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule